// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-input priority interrupt controllers, a master and a slave, into a sixteen-line interrupt source for one processor. Line `n` goes to the slave when bit 3 of `n` is set and to the master otherwise, and bits 2..0 of `n` select the controller input. Each controller latches rising edges into a request register and keeps an in-service register. Requests resolve at a fixed priority, with input 0 highest. Whenever the slave has a request that outranks its in-service set, that request appears on master input 2 as a pending request, so one slave source reaches the processor through the master.

The processor sees one interrupt output. It takes an interrupt with a single-cycle acknowledge strobe. The block then picks the winner, goes down into the slave when the master winner is the cascade input, updates the request and in-service registers, and presents an 8-bit vector with the 4-bit line number on the next cycle. A second strobe, the poll read, returns only the line number. It retires the winner outright and switches the master status view to the in-service register. If there is no winner, both strobes report input 7 of the controller concerned as a spurious source.

Top module: `cascade_pic_ack`

## Requirements
- R1: A rising edge on `irq_lines[n]` sets request bit `n%8` of the master (n<8) or the slave (n>=8). `irq_lines[2]` has no effect, because master input 2 is reserved for the cascade.
- R2: A request bit is set only by a low-to-high transition. A line that stays high after its request is taken raises no new request.
- R3: A controller's winner is its lowest-numbered unmasked (`irq_mask` bit 0) pending input, and only if that input is numbered below every in-service input. `int_out` is high exactly when the master has a winner.
- R4: When the slave has a winner and neither strobe is active, master request bit 2 is set on the next clock edge.
- R5: An acknowledge with master winner `m` != 2 clears master request `m` and sets master in-service `m`. The result is `ack_vector = {mst_base, m[2:0]}` and `ack_line = m`.
- R6: An acknowledge with master winner 2 and slave winner `s` treats master input 2 as in R5, clears slave request `s` and sets slave in-service `s`. The result is `ack_vector = {slv_base, s}` and `ack_line = s + 8`.
- R7: An acknowledge with master winner 2 and no slave winner leaves the slave unchanged and returns `ack_vector = {slv_base, 3'd7}` and `ack_line = 15`.
- R8: An acknowledge with no master winner changes no request or in-service bit and returns `ack_vector = {mst_base, 3'd7}` and `ack_line = 7`.
- R9: While `auto_eoi` is high, an acknowledge sets no in-service bit.
- R10: `ack_vector` and `ack_line` update on the clock edge that samples `ack_stb` and hold until the next acknowledge. Both are 0 after reset.
- R11: A poll read clears both request and in-service bits of the master winner and reports its number on `poll_line`. For master winner 2 the slave winner `s` is cleared in the same way and `poll_line = s + 8`, or 15 if the slave has none. With no master winner `poll_line = 7`.
- R12: `stat_data` shows the master request register after reset and after a `stat_sel_irr` strobe. It shows the master in-service register after a poll read.
- R13: `eoi_stb` clears in-service bit `eoi_line%8` of the controller chosen by `eoi_line[3]`. If an acknowledge and a poll read arrive in the same cycle, the poll read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 16 | Edge-sensitive interrupt lines 0..15 |
| irq_mask | input | 16 | Per-line mask, 1 blocks the line |
| mst_base | input | 5 | Upper vector bits for master sources |
| slv_base | input | 5 | Upper vector bits for slave sources |
| auto_eoi | input | 1 | Acknowledge leaves in-service bits clear |
| ack_stb | input | 1 | Single-cycle interrupt acknowledge |
| poll_stb | input | 1 | Single-cycle memory-mapped poll read |
| eoi_stb | input | 1 | Clear one in-service bit |
| eoi_line | input | 4 | Line whose in-service bit is cleared |
| stat_sel_irr | input | 1 | Switch master status view back to requests |
| int_out | output | 1 | Interrupt request to the processor |
| ack_vector | output | 8 | Vector of the last acknowledge |
| ack_line | output | 4 | Line number of the last acknowledge |
| poll_line | output | 4 | Line number of the last poll read |
| stat_data | output | 8 | Master request or in-service register |

## Verification
The bench aims at the cascade path. If the forwarding to master input 2 is wrong, a slave-only request either never raises `int_out` or raises it one cycle too early. If the two-level lookup is wrong, it returns a master-based vector for a slave source. The spurious cases come next. A design that drops the slave fallback would return a stale slave number instead of line 15, and one that mishandles the empty master would change state or report something other than line 7. Priority against in-service bits, edge-only capture on a line held high, auto-EOI, the status view after a poll, and an acknowledge colliding with a poll are each driven on purpose, and a long pseudo-random stretch is compared against a behavioural model on every clock.

// File: rtl/pic_pkg.sv
// Shared constants for the cascaded interrupt sequencer.
// Assumes exactly two controllers: index 0 is the master, index 1 the slave.
package pic_pkg;
    localparam int N_CHIPS  = 2;
    localparam int CHIP_MST = 0;
    localparam int CHIP_SLV = 1;
endpackage

// File: rtl/pic_prio.sv
// Fixed-priority resolver for one controller.
// Picks the lowest-numbered pending input and reports it as a winner only
// when it is numbered below every in-service input. Purely combinational.
module pic_prio #(
    parameter int N_IN = 8,
    localparam int IDX_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  pend,
    input  logic [N_IN-1:0]  insvc,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx
);
    logic             p_found;
    logic             s_found;
    logic [IDX_W-1:0] p_idx;
    logic [IDX_W-1:0] s_idx;

    // lowest set bit of the pending and of the in-service vector
    always_comb begin
        p_found = 1'b0;
        s_found = 1'b0;
        p_idx   = '0;
        s_idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (pend[i]) begin
                p_found = 1'b1;
                p_idx   = IDX_W'(i);
            end
            if (insvc[i]) begin
                s_found = 1'b1;
                s_idx   = IDX_W'(i);
            end
        end
    end

    // a request wins only if it outranks the highest in-service input
    always_comb begin
        win_valid = p_found && (!s_found || (p_idx < s_idx));
        win_idx   = p_idx;
    end
endmodule

// File: rtl/pic_chip.sv
// State of one eight-input controller: edge history, request register and
// in-service register, plus its priority resolver.
// Assumes set and clear vectors come from the sequencer; a new edge or a
// cascade set wins over a clear of the same request bit in one cycle.
module pic_chip #(
    parameter int N_IN = 8,
    localparam int IDX_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  line_in,
    input  logic [N_IN-1:0]  mask,
    input  logic [N_IN-1:0]  casc_set,
    input  logic [N_IN-1:0]  clr_irr,
    input  logic [N_IN-1:0]  set_isr,
    input  logic [N_IN-1:0]  clr_isr,
    output logic [N_IN-1:0]  irr,
    output logic [N_IN-1:0]  isr,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx
);
    logic [N_IN-1:0] last_q;
    logic [N_IN-1:0] irr_q;
    logic [N_IN-1:0] isr_q;

    // capture rising edges and apply sequencer updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            irr_q  <= '0;
            isr_q  <= '0;
        end else begin
            last_q <= line_in;
            irr_q  <= (irr_q & ~clr_irr) | (line_in & ~last_q) | casc_set;
            isr_q  <= (isr_q & ~clr_isr) | set_isr;
        end
    end

    assign irr = irr_q;
    assign isr = isr_q;

    pic_prio #(.N_IN(N_IN)) u_prio (
        .pend      (irr_q & ~mask),
        .insvc     (isr_q),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );
endmodule

// File: rtl/pic_ack_seq.sv
// Acknowledge and poll sequencer for a master/slave controller pair.
// Decodes the strobes against both winners into per-controller set/clear
// vectors, drives the cascade request into master input CASC_IN, and
// registers the vector, line and poll results. Assumes single-cycle strobes.
module pic_ack_seq
    import pic_pkg::*;
#(
    parameter int N_IN    = 8,
    parameter int VEC_W   = 8,
    parameter int CASC_IN = 2,
    parameter int SPUR_IN = 7,
    localparam int IDX_W  = $clog2(N_IN),
    localparam int LINE_W = IDX_W + 1,
    localparam int BASE_W = VEC_W - IDX_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ack_stb,
    input  logic                           poll_stb,
    input  logic                           eoi_stb,
    input  logic [LINE_W-1:0]              eoi_line,
    input  logic                           stat_sel_irr,
    input  logic                           auto_eoi,
    input  logic [BASE_W-1:0]              mst_base,
    input  logic [BASE_W-1:0]              slv_base,
    input  logic                           m_valid,
    input  logic [IDX_W-1:0]               m_idx,
    input  logic                           s_valid,
    input  logic [IDX_W-1:0]               s_idx,
    output logic [N_CHIPS-1:0][N_IN-1:0]   casc_set,
    output logic [N_CHIPS-1:0][N_IN-1:0]   clr_irr,
    output logic [N_CHIPS-1:0][N_IN-1:0]   set_isr,
    output logic [N_CHIPS-1:0][N_IN-1:0]   clr_isr,
    output logic [VEC_W-1:0]               ack_vector,
    output logic [LINE_W-1:0]              ack_line,
    output logic [LINE_W-1:0]              poll_line,
    output logic                           rd_isr
);
    localparam logic [IDX_W-1:0] CASC = IDX_W'(CASC_IN);
    localparam logic [IDX_W-1:0] SPUR = IDX_W'(SPUR_IN);

    logic              poll_go;
    logic              via_slave;
    logic [IDX_W-1:0]  slv_pick;
    logic [LINE_W-1:0] res_line;
    logic [VEC_W-1:0]  res_vec;

    // an acknowledge in the same cycle shadows a poll read
    assign poll_go   = poll_stb & ~ack_stb;
    assign via_slave = m_valid && (m_idx == CASC);
    assign slv_pick  = s_valid ? s_idx : SPUR;

    // result of the two-level lookup, shared by acknowledge and poll
    always_comb begin
        if (!m_valid) begin
            res_line = {1'b0, SPUR};
            res_vec  = {mst_base, SPUR};
        end else if (via_slave) begin
            res_line = {1'b1, slv_pick};
            res_vec  = {slv_base, slv_pick};
        end else begin
            res_line = {1'b0, m_idx};
            res_vec  = {mst_base, m_idx};
        end
    end

    // set/clear vectors for both controllers
    always_comb begin
        casc_set = '0;
        clr_irr  = '0;
        set_isr  = '0;
        clr_isr  = '0;
        if (s_valid && !ack_stb && !poll_stb) begin
            casc_set[CHIP_MST][CASC] = 1'b1;
        end
        if (eoi_stb) begin
            clr_isr[eoi_line[IDX_W]][eoi_line[IDX_W-1:0]] = 1'b1;
        end
        if (ack_stb && m_valid) begin
            clr_irr[CHIP_MST][m_idx] = 1'b1;
            if (!auto_eoi) begin
                set_isr[CHIP_MST][m_idx] = 1'b1;
            end
            if (via_slave && s_valid) begin
                clr_irr[CHIP_SLV][s_idx] = 1'b1;
                if (!auto_eoi) begin
                    set_isr[CHIP_SLV][s_idx] = 1'b1;
                end
            end
        end
        if (poll_go && m_valid) begin
            clr_irr[CHIP_MST][m_idx] = 1'b1;
            clr_isr[CHIP_MST][m_idx] = 1'b1;
            if (via_slave && s_valid) begin
                clr_irr[CHIP_SLV][s_idx] = 1'b1;
                clr_isr[CHIP_SLV][s_idx] = 1'b1;
                clr_irr[CHIP_MST][CASC]  = 1'b1;
                clr_isr[CHIP_MST][CASC]  = 1'b1;
            end
        end
    end

    // hold acknowledge and poll results until the next strobe of each kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vector <= '0;
            ack_line   <= '0;
            poll_line  <= '0;
        end else begin
            if (ack_stb) begin
                ack_vector <= res_vec;
                ack_line   <= res_line;
            end
            if (poll_go) begin
                poll_line <= res_line;
            end
        end
    end

    // master status view: in-service after a poll, requests on demand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_isr <= 1'b0;
        end else if (poll_go) begin
            rd_isr <= 1'b1;
        end else if (stat_sel_irr) begin
            rd_isr <= 1'b0;
        end
    end
endmodule

// File: rtl/cascade_pic_ack.sv
// Top of the cascaded interrupt acknowledge sequencer.
// Splits the sixteen lines over two controller instances, withholds the
// cascade input from the external lines, and connects the sequencer.
// Assumes mask and vector bases are held stable by the surrounding logic.
module cascade_pic_ack
    import pic_pkg::*;
#(
    parameter int N_IN    = 8,
    parameter int VEC_W   = 8,
    parameter int CASC_IN = 2,
    parameter int SPUR_IN = 7,
    localparam int IDX_W  = $clog2(N_IN),
    localparam int LINE_W = IDX_W + 1,
    localparam int BASE_W = VEC_W - IDX_W,
    localparam int LINES  = N_CHIPS * N_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_lines,
    input  logic [LINES-1:0]  irq_mask,
    input  logic [BASE_W-1:0] mst_base,
    input  logic [BASE_W-1:0] slv_base,
    input  logic              auto_eoi,
    input  logic              ack_stb,
    input  logic              poll_stb,
    input  logic              eoi_stb,
    input  logic [LINE_W-1:0] eoi_line,
    input  logic              stat_sel_irr,
    output logic              int_out,
    output logic [VEC_W-1:0]  ack_vector,
    output logic [LINE_W-1:0] ack_line,
    output logic [LINE_W-1:0] poll_line,
    output logic [N_IN-1:0]   stat_data
);
    localparam logic [N_IN-1:0] CASC_BIT = N_IN'(1) << CASC_IN;

    logic [N_CHIPS-1:0][N_IN-1:0]  casc_set;
    logic [N_CHIPS-1:0][N_IN-1:0]  clr_irr;
    logic [N_CHIPS-1:0][N_IN-1:0]  set_isr;
    logic [N_CHIPS-1:0][N_IN-1:0]  clr_isr;
    logic [N_CHIPS-1:0][N_IN-1:0]  chip_irr;
    logic [N_CHIPS-1:0][N_IN-1:0]  chip_isr;
    logic [N_CHIPS-1:0]            chip_valid;
    logic [N_CHIPS-1:0][IDX_W-1:0] chip_idx;
    logic                          rd_isr;

    logic             m_valid;
    logic [IDX_W-1:0] m_idx;
    logic             s_valid;
    logic [IDX_W-1:0] s_idx;
    logic [N_IN-1:0]  m_irr;
    logic [N_IN-1:0]  m_isr;

    // one controller per chip index; the master never sees line CASC_IN
    for (genvar c = 0; c < N_CHIPS; c++) begin : g_chip
        localparam logic [N_IN-1:0] EXT_KEEP = (c == CHIP_MST) ? ~CASC_BIT : '1;
        pic_chip #(.N_IN(N_IN)) u_chip (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_in   (irq_lines[c*N_IN +: N_IN] & EXT_KEEP),
            .mask      (irq_mask[c*N_IN +: N_IN]),
            .casc_set  (casc_set[c]),
            .clr_irr   (clr_irr[c]),
            .set_isr   (set_isr[c]),
            .clr_isr   (clr_isr[c]),
            .irr       (chip_irr[c]),
            .isr       (chip_isr[c]),
            .win_valid (chip_valid[c]),
            .win_idx   (chip_idx[c])
        );
    end

    assign m_valid = chip_valid[CHIP_MST];
    assign m_idx   = chip_idx[CHIP_MST];
    assign s_valid = chip_valid[CHIP_SLV];
    assign s_idx   = chip_idx[CHIP_SLV];
    assign m_irr   = chip_irr[CHIP_MST];
    assign m_isr   = chip_isr[CHIP_MST];

    pic_ack_seq #(
        .N_IN    (N_IN),
        .VEC_W   (VEC_W),
        .CASC_IN (CASC_IN),
        .SPUR_IN (SPUR_IN)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_stb      (ack_stb),
        .poll_stb     (poll_stb),
        .eoi_stb      (eoi_stb),
        .eoi_line     (eoi_line),
        .stat_sel_irr (stat_sel_irr),
        .auto_eoi     (auto_eoi),
        .mst_base     (mst_base),
        .slv_base     (slv_base),
        .m_valid      (m_valid),
        .m_idx        (m_idx),
        .s_valid      (s_valid),
        .s_idx        (s_idx),
        .casc_set     (casc_set),
        .clr_irr      (clr_irr),
        .set_isr      (set_isr),
        .clr_isr      (clr_isr),
        .ack_vector   (ack_vector),
        .ack_line     (ack_line),
        .poll_line    (poll_line),
        .rd_isr       (rd_isr)
    );

    // processor request and master status view
    assign int_out   = m_valid;
    assign stat_data = rd_isr ? m_isr : m_irr;
endmodule

// File: rtl/cascade_pic_ack_chk.sv
// Property checker for cascade_pic_ack, attached with bind below.
// Observes ports and the master/slave state nets of the top module.
module cascade_pic_ack_chk #(
    parameter int N_IN    = 8,
    parameter int VEC_W   = 8,
    parameter int CASC_IN = 2,
    parameter int SPUR_IN = 7,
    localparam int IDX_W  = $clog2(N_IN),
    localparam int LINE_W = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_stb,
    input logic              poll_stb,
    input logic              auto_eoi,
    input logic              int_out,
    input logic [VEC_W-1:0]  ack_vector,
    input logic [LINE_W-1:0] ack_line,
    input logic [N_IN-1:0]   stat_data,
    input logic              m_valid,
    input logic [IDX_W-1:0]  m_idx,
    input logic [N_IN-1:0]   m_irr,
    input logic [N_IN-1:0]   m_isr,
    input logic              s_valid
);
    assert_int_has_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (m_irr != '0));

    assert_cascade_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !ack_stb && !poll_stb) |=> m_irr[CASC_IN]);

    assert_isr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && m_valid && !auto_eoi) |=> m_isr[$past(m_idx)]);

    assert_spurious_mst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !m_valid) |=> (ack_line == LINE_W'(SPUR_IN)));

    assert_auto_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && m_valid && auto_eoi) |=> !m_isr[$past(m_idx)]);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_stb |=> ($stable(ack_vector) && $stable(ack_line)));

    assert_vec_line_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> (ack_vector[IDX_W-1:0] == ack_line[IDX_W-1:0]));

    assert_status_isr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_stb && !ack_stb) |=> (stat_data == m_isr));
endmodule

bind cascade_pic_ack cascade_pic_ack_chk #(
    .N_IN    (N_IN),
    .VEC_W   (VEC_W),
    .CASC_IN (CASC_IN),
    .SPUR_IN (SPUR_IN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_stb    (ack_stb),
    .poll_stb   (poll_stb),
    .auto_eoi   (auto_eoi),
    .int_out    (int_out),
    .ack_vector (ack_vector),
    .ack_line   (ack_line),
    .stat_data  (stat_data),
    .m_valid    (m_valid),
    .m_idx      (m_idx),
    .m_irr      (m_irr),
    .m_isr      (m_isr),
    .s_valid    (s_valid)
);

// File: tb/sim_cascade_pic_ack.sv
// Bench for cascade_pic_ack: directed scenarios plus a pseudo-random stretch,
// all compared every clock against a behavioural model kept in this file.
module sim_cascade_pic_ack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lines = '0;
    logic [15:0] mask = '0;
    logic [4:0]  m_base = 5'h04;
    logic [4:0]  s_base = 5'h0E;
    logic        aeoi = 1'b0;
    logic        ack = 1'b0;
    logic        poll = 1'b0;
    logic        eoi = 1'b0;
    logic [3:0]  eoi_ln = '0;
    logic        stat_irr = 1'b0;
    logic        int_out;
    logic [7:0]  ack_vector;
    logic [3:0]  ack_line;
    logic [3:0]  poll_line;
    logic [7:0]  stat_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic [7:0]  mirr = '0, misr = '0, sirr = '0, sisr = '0;
    logic [15:0] last = '0;
    logic [7:0]  evec = '0;
    logic [3:0]  eline = '0, epoll = '0;
    bit          erd = 1'b0;

    always #4 clk = ~clk;

    cascade_pic_ack u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .irq_mask(mask),
        .mst_base(m_base), .slv_base(s_base), .auto_eoi(aeoi),
        .ack_stb(ack), .poll_stb(poll), .eoi_stb(eoi), .eoi_line(eoi_ln),
        .stat_sel_irr(stat_irr), .int_out(int_out), .ack_vector(ack_vector),
        .ack_line(ack_line), .poll_line(poll_line), .stat_data(stat_data)
    );

    function automatic int win(logic [7:0] irr, logic [7:0] isr, logic [7:0] msk);
        int p = -1;
        int s = 8;
        for (int i = 7; i >= 0; i--) begin
            if (irr[i] && !msk[i]) p = i;
            if (isr[i]) s = i;
        end
        return (p >= 0 && p < s) ? p : -1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // next state as the coming clock edge should produce it
    task automatic model_step();
        int mw = win(mirr, misr, mask[7:0]);
        int sw = win(sirr, sisr, mask[15:8]);
        logic [15:0] rise = lines & ~last;
        logic [7:0] nmirr = mirr, nmisr = misr, nsirr = sirr, nsisr = sisr;
        int sel;
        rise[2] = 1'b0;
        last = lines;
        if (eoi) begin
            if (eoi_ln < 8) nmisr[eoi_ln[2:0]] = 1'b0;
            else nsisr[eoi_ln[2:0]] = 1'b0;
        end
        if (ack) begin
            if (mw < 0) begin
                evec = {m_base, 3'd7}; eline = 4'd7;
            end else begin
                nmirr[mw] = 1'b0;
                if (!aeoi) nmisr[mw] = 1'b1;
                if (mw == 2) begin
                    if (sw >= 0) begin
                        nsirr[sw] = 1'b0;
                        if (!aeoi) nsisr[sw] = 1'b1;
                        sel = sw;
                    end else sel = 7;
                    evec = {s_base, 3'(sel)}; eline = 4'(sel + 8);
                end else begin
                    evec = {m_base, 3'(mw)}; eline = 4'(mw);
                end
            end
        end else if (poll) begin
            if (mw < 0) epoll = 4'd7;
            else begin
                nmirr[mw] = 1'b0; nmisr[mw] = 1'b0;
                if (mw == 2) begin
                    if (sw >= 0) begin
                        nsirr[sw] = 1'b0; nsisr[sw] = 1'b0;
                        epoll = 4'(sw + 8);
                    end else epoll = 4'd15;
                end else epoll = 4'(mw);
            end
        end
        if (!ack && !poll && sw >= 0) nmirr[2] = 1'b1;
        nmirr = nmirr | rise[7:0];
        nsirr = nsirr | rise[15:8];
        if (poll && !ack) erd = 1'b1;
        else if (stat_irr) erd = 1'b0;
        mirr = nmirr; misr = nmisr; sirr = nsirr; sisr = nsisr;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("MODEL int_out R3", int'(int_out), int'(win(mirr, misr, mask[7:0]) >= 0));
        chk("MODEL ack_vector R10", int'(ack_vector), int'(evec));
        chk("MODEL ack_line R10", int'(ack_line), int'(eline));
        chk("MODEL poll_line R11", int'(poll_line), int'(epoll));
        chk("MODEL stat_data R12", int'(stat_data), int'(erd ? misr : mirr));
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_poll();
        poll = 1'b1; tick(); poll = 1'b0;
    endtask

    task automatic do_eoi(input int ln);
        eoi = 1'b1; eoi_ln = 4'(ln); tick(); eoi = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 / R12 reset state
        chk("R10 reset vector", int'(ack_vector), 0);
        chk("R12 reset status", int'(stat_data), 0);
        chk("R3 reset int_out", int'(int_out), 0);

        // R1, R5: master line 3
        lines[3] = 1'b1; tick();
        chk("R1 line3 raises int", int'(int_out), 1);
        do_ack();
        chk("R5 vector line3", int'(ack_vector), 8'h23);
        chk("R5 line line3", int'(ack_line), 3);
        // R2: held line gives no new request
        do_eoi(3); tick();
        chk("R2 held line no request", int'(int_out), 0);
        lines[3] = 1'b0; tick();

        // R3 priority and R13 end of interrupt
        lines[5] = 1'b1; lines[1] = 1'b1; tick();
        do_ack();
        chk("R3 lowest wins", int'(ack_line), 1);
        chk("R3 blocked by in-service", int'(int_out), 0);
        do_eoi(1);
        chk("R13 eoi reopens", int'(int_out), 1);
        do_ack();
        chk("R3 next winner", int'(ack_line), 5);
        do_eoi(5);
        lines[5] = 1'b0; lines[1] = 1'b0; tick();

        // R1: external line 2 ignored
        lines[2] = 1'b1; tick(); tick();
        chk("R1 line2 ignored", int'(int_out), 0);
        lines[2] = 1'b0; tick();

        // R4, R6: slave line 12
        lines[12] = 1'b1; tick();
        chk("R4 not yet forwarded", int'(int_out), 0);
        tick();
        chk("R4 forwarded", int'(int_out), 1);
        do_ack();
        chk("R6 slave vector", int'(ack_vector), 8'h74);
        chk("R6 slave line", int'(ack_line), 12);
        do_eoi(12); do_eoi(2);
        lines[12] = 1'b0; tick();

        // R8: nothing pending
        do_ack();
        chk("R8 master spurious line", int'(ack_line), 7);
        chk("R8 master spurious vector", int'(ack_vector), 8'h27);

        // R7: slave request withdrawn by mask
        lines[9] = 1'b1; tick(); tick();
        mask[9] = 1'b1;
        do_ack();
        chk("R7 slave spurious line", int'(ack_line), 15);
        chk("R7 slave spurious vector", int'(ack_vector), 8'h77);
        mask[9] = 1'b0;
        do_eoi(2); tick();
        do_ack();
        chk("R7 slave request kept", int'(ack_line), 9);
        do_eoi(9); do_eoi(2);
        lines[9] = 1'b0; tick();

        // R9: auto end of interrupt
        lines[6] = 1'b1; tick();
        aeoi = 1'b1;
        do_ack();
        chk("R9 line6 taken", int'(ack_line), 6);
        aeoi = 1'b0;
        do_poll();
        chk("R11 empty poll", int'(poll_line), 7);
        chk("R9 no in-service bit", int'(stat_data), 0);
        lines[6] = 1'b0; tick();

        // R11: poll reads
        lines[4] = 1'b1; tick();
        do_poll();
        chk("R11 master poll", int'(poll_line), 4);
        chk("R11 poll clears in-service", int'(stat_data), 0);
        lines[11] = 1'b1; tick(); tick();
        do_poll();
        chk("R11 slave poll", int'(poll_line), 11);
        chk("R11 slave poll int", int'(int_out), 0);
        lines[4] = 1'b0; lines[11] = 1'b0; tick();

        // R12: status view back to requests
        stat_irr = 1'b1; tick(); stat_irr = 1'b0;
        lines[0] = 1'b1; tick();
        chk("R12 status shows requests", int'(stat_data), 1);
        // R13: acknowledge shadows poll
        ack = 1'b1; poll = 1'b1; tick(); ack = 1'b0; poll = 1'b0;
        chk("R13 ack taken", int'(ack_line), 0);
        chk("R13 poll ignored", int'(poll_line), 11);
        lines[0] = 1'b0; do_eoi(0);

        // pseudo-random stretch
        for (int n = 0; n < 3000; n++) begin
            lines    = 16'($urandom);
            if ((n % 64) == 0) mask = 16'($urandom) & 16'h0F0F;
            ack      = ($urandom % 6) == 0;
            poll     = ($urandom % 9) == 0;
            eoi      = ($urandom % 4) == 0;
            eoi_ln   = 4'($urandom);
            stat_irr = ($urandom % 7) == 0;
            aeoi     = ($urandom % 5) == 0;
            tick();
        end
        ack = 1'b0; poll = 1'b0; eoi = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule